// File: doc/BRIEF.md
# Nonrestoring Sequential Integer Divider

This block divides an unsigned dividend by an unsigned divisor of the same width and returns the quotient and the remainder. It takes one quotient bit per clock. A partial remainder one bit wider than the operands is kept as a signed value. On each step the partial remainder and the dividend/quotient register shift left together by one place. The sign of the partial remainder before the shift then picks the operation: the divisor is subtracted when the sign is clear and added when it is set. A subtraction that goes negative is never undone. The next step adds the divisor instead, and one correction add after the last step repairs a negative remainder.

A caller pulses `start_i` with both operands while the block is idle. `busy_o` stays high until the result is ready, and `done_o` pulses for one cycle when the quotient and remainder outputs are loaded. Those outputs hold their values until the next result. A zero divisor skips the iterations and reports a flagged result at once.

Top module: `nrdiv_top`

## Requirements
- R1: After reset, busy_o, done_o, div_zero_o, quotient_o and remainder_o are all 0.
- R2: A start_i seen while idle with a nonzero divisor raises busy_o on the next cycle. done_o rises exactly N+1 clock edges after the edge that sampled start_i: N shift steps plus one correction step. busy_o is low whenever done_o is high.
- R3: For a nonzero divisor, quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor, both as unsigned N-bit values. For example, 8 divided by 3 gives quotient 2 and remainder 2.
- R4: When done_o is high and div_zero_o is low, remainder_o is strictly less than the divisor.
- R5: done_o is high for exactly one cycle per accepted operation.
- R6: A start_i with a zero divisor completes on the very next edge and never raises busy_o. It sets div_zero_o to 1, quotient_o to all ones, and remainder_o to the dividend.
- R7: start_i and the operand inputs are ignored while busy_o is high. The running operation finishes on its original schedule with its original operands.
- R8: quotient_o, remainder_o and div_zero_o change only on the edge that raises done_o. div_zero_o is cleared by the next completed nonzero-divisor operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation when idle |
| dividend_i | input | N | Unsigned dividend, sampled with start_i |
| divisor_i | input | N | Unsigned divisor, sampled with start_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| quotient_o | output | N | Quotient, held until the next result |
| remainder_o | output | N | Remainder, held until the next result |
| div_zero_o | output | 1 | Last result came from a zero divisor |

## Verification
The bench drives inputs on falling edges and samples outputs on falling edges. It counts edges from the one that sampled start_i. For a nonzero divisor it expects busy_o high and done_o low at each of the first N+1 samples, and done_o together with the result at the next sample, which follows edge N+1. For a zero divisor it expects done_o and the flagged result at the first sample after the start edge and done_o low at the sample after that. Every pair of dividend and divisor at a width of 5 is swept and compared against integer division computed in the bench. Separate cases cover a start issued mid-operation and the holding of results between operations.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } step_op_e;

    // A negative partial remainder is pulled back up by adding the divisor.
    function automatic step_op_e pick_op(input logic sign);
        return sign ? OP_ADD : OP_SUB;
    endfunction

    // A non-negative partial remainder after the step yields a quotient one.
    function automatic logic quotient_bit(input logic sign);
        return ~sign;
    endfunction

endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic zero_div_i,
    output logic load_o,
    output logic zload_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign load_o  = accept && !zero_div_i;
    assign zload_o = accept && zero_div_i;
    assign step_o  = (state_q == ST_RUN);
    assign fix_o   = (state_q == ST_FIX);
    assign busy_o  = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (load_o) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a step is only taken while fewer than N steps have run
    assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (cnt_q <= LAST));

    // R2: the correction step always follows the last shift step
    assert_fix_after_run_R2: assert property (@(posedge clk) disable iff (rst)
        (step_o && cnt_q == LAST) |=> fix_o);

    // R7: an accepted start is only possible from the idle state
    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !(load_o || zload_o));

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0]   a_i,
    input  logic [N-1:0] q_i,
    input  logic [N-1:0] m_i,
    output logic [N:0]   a_o,
    output logic [N-1:0] q_o
);
    logic [N:0] shifted;
    logic [N:0] m_ext;
    step_op_e   op;

    assign shifted = {a_i[N-1:0], q_i[N-1]};
    assign m_ext   = {1'b0, m_i};
    assign op      = pick_op(a_i[N]);

    always_comb begin
        if (op == OP_ADD) a_o = shifted + m_ext;
        else              a_o = shifted - m_ext;
        q_o = {q_i[N-2:0], quotient_bit(a_o[N])};
    end

endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int N = 8
) (
    input  logic [N:0]   a_i,
    input  logic [N-1:0] m_i,
    output logic [N-1:0] rem_o
);
    logic [N:0] fixed;

    always_comb begin
        fixed = a_i[N] ? (a_i + {1'b0, m_i}) : a_i;
        rem_o = fixed[N-1:0];
    end

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
    import nrdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [N-1:0] dividend_i,
    input  logic [N-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] quotient_o,
    output logic [N-1:0] remainder_o,
    output logic         div_zero_o
);
    logic [N:0]   a_q, a_n;
    logic [N-1:0] q_q, q_n, m_q, rem_fix;
    logic         load, zload, step, fix, zero_div;

    assign zero_div = (divisor_i == '0);

    nrdiv_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .zero_div_i(zero_div),
        .load_o(load), .zload_o(zload), .step_o(step), .fix_o(fix),
        .busy_o(busy_o)
    );

    nrdiv_step #(.N(N)) u_step (
        .a_i(a_q), .q_i(q_q), .m_i(m_q), .a_o(a_n), .q_o(q_n)
    );

    nrdiv_fix #(.N(N)) u_fix (
        .a_i(a_q), .m_i(m_q), .rem_o(rem_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q         <= '0;
            q_q         <= '0;
            m_q         <= '0;
            done_o      <= 1'b0;
            div_zero_o  <= 1'b0;
            quotient_o  <= '0;
            remainder_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (load) begin
                a_q <= '0;
                q_q <= dividend_i;
                m_q <= divisor_i;
            end
            if (zload) begin
                done_o      <= 1'b1;
                div_zero_o  <= 1'b1;
                quotient_o  <= '1;
                remainder_o <= dividend_i;
            end
            if (step) begin
                a_q <= a_n;
                q_q <= q_n;
            end
            if (fix) begin
                done_o      <= 1'b1;
                div_zero_o  <= 1'b0;
                quotient_o  <= q_q;
                remainder_o <= rem_fix;
            end
        end
    end

    // R2: result ready and busy never overlap
    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    // R2: a nonzero-divisor start while idle makes the block busy
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && divisor_i != '0) |=> busy_o);

    // R4: a normal result leaves a remainder below the divisor
    assert_rem_lt_div_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !div_zero_o) |-> (remainder_o < m_q));

    // R5: done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: a zero-divisor start completes next cycle with an all-ones quotient
    assert_zero_div_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && divisor_i == '0) |=>
            (done_o && div_zero_o && !busy_o && quotient_o == '1));

    // R7: the divisor register is frozen while an operation runs
    assert_divisor_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(m_q));

    // R8: results change only together with a done pulse
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(quotient_o) || !$stable(remainder_o) || !$stable(div_zero_o))
            |-> done_o);

endmodule

// File: tb/nrdiv_top_bench.sv
module nrdiv_top_bench;
    localparam int N = 5;
    localparam int MAXV = (1 << N);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [N-1:0] dividend_i = '0;
    logic [N-1:0] divisor_i = '0;
    logic         busy_o, done_o, div_zero_o;
    logic [N-1:0] quotient_o, remainder_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    nrdiv_top #(.N(N)) u_nrdiv_top (
        .clk(clk), .rst(rst), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o),
        .div_zero_o(div_zero_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one operation; optionally inject a start while busy (R7).
    task automatic run_div(input int dd, input int dv, input bit inject);
        int eq, er;
        @(negedge clk);
        start_i = 1'b1;
        dividend_i = N'(dd);
        divisor_i = N'(dv);
        @(negedge clk);
        start_i = 1'b0;
        if (dv == 0) begin
            chk("R6 done", int'(done_o), 1);
            chk("R6 busy", int'(busy_o), 0);
            chk("R6 flag", int'(div_zero_o), 1);
            chk("R6 quotient", int'(quotient_o), MAXV - 1);
            chk("R6 remainder", int'(remainder_o), dd);
            @(negedge clk);
            chk("R5 done low", int'(done_o), 0);
        end else begin
            eq = dd / dv;
            er = dd % dv;
            for (int i = 0; i <= N; i++) begin
                if (i > 0) @(negedge clk);
                if (inject && i == 1) begin
                    start_i = 1'b1;
                    dividend_i = N'(5);
                    divisor_i = '0;
                end
                if (inject && i == 2) start_i = 1'b0;
                chk("R2 busy", int'(busy_o), 1);
                chk("R2 done early", int'(done_o), 0);
            end
            @(negedge clk);
            chk("R2 done", int'(done_o), 1);
            chk("R2 busy at done", int'(busy_o), 0);
            chk(inject ? "R7 quotient" : "R3 quotient", int'(quotient_o), eq);
            chk(inject ? "R7 remainder" : "R3 remainder", int'(remainder_o), er);
            chk("R4 remainder below divisor", int'(remainder_o < N'(dv)), 1);
            chk("R8 flag cleared", int'(div_zero_o), 0);
            @(negedge clk);
            chk("R5 done low", int'(done_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 flag", int'(div_zero_o), 0);
        chk("R1 quotient", int'(quotient_o), 0);
        chk("R1 remainder", int'(remainder_o), 0);

        run_div(8, 3, 1'b0);  // R3 example: 2 remainder 2

        for (int dd = 0; dd < MAXV; dd++)
            for (int dv = 0; dv < MAXV; dv++)
                run_div(dd, dv, 1'b0);

        run_div(27, 4, 1'b1);  // R7: expect 6 remainder 3

        // R8: results hold while idle and inputs move
        run_div(29, 6, 1'b0);
        dividend_i = N'(1);
        divisor_i = N'(1);
        repeat (4) @(negedge clk);
        chk("R8 quotient hold", int'(quotient_o), 4);
        chk("R8 remainder hold", int'(remainder_o), 5);
        run_div(9, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 flag hold", int'(div_zero_o), 1);
        run_div(31, 31, 1'b0);
        chk("R8 flag clear", int'(div_zero_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule